// File: doc/BRIEF.md
# Serial EEPROM Configuration Bank Loader

This block moves configuration banks between an on-chip byte RAM and an external two-wire (I2C) serial EEPROM. It drives a byte-level bus master by issuing one operation at a time: start, stop, write one byte, or read one byte. It also drives the read/write port of the configuration RAM. The bit-level bus timing belongs to the byte master and is not part of this block.

On a load request the block reads every bank from the EEPROM into RAM. It then compares each bank with the 8-bit check byte stored right after it, and reports which banks are valid and whether any fault occurred. On a store request it copies every RAM bank back to the EEPROM one byte at a time. Each bank is followed by a freshly computed check byte. After each byte the block polls the device until the device has finished its internal write cycle. The EEPROM location is 11 bits wide. Its upper three bits travel inside the device-address byte, so devices from 128 bytes up to 2 Kbytes are supported.

Top module: `cfg_nvm_loader`

## Requirements
- R1: After reset, `busy`, `done`, `cfg_fault`, `ram_we`, `i2c_req` and all `bank_valid` bits are 0.
- R2: Every EEPROM byte access starts with a device-address byte {DEV_BASE[6:3], a[10:8], rw}, with rw=0 for write and rw=1 for read, followed by a word-address byte a[7:0]. A read uses the order start, device byte (rw=0), word byte, start, device byte (rw=1), read, stop.
- R3: Data byte i of bank b is at EEPROM location EE_BASE + b*(BB+1) + i and at RAM address b*BB + i. The bank's check byte is at EEPROM location EE_BASE + b*(BB+1) + BB.
- R4: The check byte is a CRC over the bank's BB data bytes in address order, with polynomial x^8+x^2+x+1 (0x07), initial value 0x00, most significant bit first. A bank of all zero bytes yields 0x00.
- R5: A load writes every data byte into RAM. It then sets `bank_valid[b]` to 1 exactly when bank b's computed CRC equals its stored check byte. It sets `cfg_fault` if any bank mismatches. A load clears `bank_valid` when it starts, and a store leaves `bank_valid` unchanged.
- R6: If the device does not acknowledge a written byte during a load or a store (outside polling), the block issues a stop, sets `cfg_fault` and finishes. It makes no further RAM writes in that operation.
- R7: A store writes each data byte and then the check byte. Each byte is a single write of start, device byte, word byte, data byte, stop. After each byte the block repeats start, device byte (rw=0), stop until the device acknowledges, and only then moves to the next byte.
- R8: After POLL_MAX unacknowledged polls for one byte, the store ends with `cfg_fault` set and writes no further byte.
- R9: `busy` rises in the cycle after a request is accepted. `done` is a one-cycle pulse in the same cycle that `busy` falls. Requests that arrive while `busy` is 1 are ignored. If both requests arrive together, the load is performed.
- R10: `i2c_req` is high for one cycle per operation, and no new operation is issued until `i2c_done` has answered the previous one. Operation codes on `i2c_op`: 0 start, 1 stop, 2 write byte, 3 read byte (the byte is read and then not acknowledged). `i2c_ack`=1 means the device acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_req | input | 1 | Request to read all banks from the EEPROM |
| store_req | input | 1 | Request to write all banks to the EEPROM |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when an operation ends |
| cfg_fault | output | 1 | Last operation saw a CRC mismatch, an acknowledge failure or a poll timeout |
| bank_valid | output | NB | Per-bank CRC match from the last load |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | RAW | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after the address |
| i2c_req | output | 1 | One-cycle operation request to the byte master |
| i2c_op | output | 2 | Operation code |
| i2c_wbyte | output | 8 | Byte to transmit for a write operation |
| i2c_done | input | 1 | Byte master finished the current operation |
| i2c_ack | input | 1 | Acknowledge seen on a write operation |
| i2c_rbyte | input | 8 | Byte received by a read operation |

## Verification
The assertions assume that the byte master answers each request with exactly one `i2c_done` pulse. The pulse must come at least one cycle after the request, and none may arrive unrequested. They also assume the RAM returns data one cycle after the address. The bench's bus model holds to this: it counts a random latency of one to three cycles from each sampled request. Its EEPROM model decodes the block bits from the device byte, so a wrong address fold corrupts the data. The model stays busy for a chosen number of polls after each stop, and it can pretend to be absent. The bank layout is placed across a 256-byte boundary on purpose.

// File: rtl/cfg_nvm_pkg.sv
package cfg_nvm_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } i2c_op_e;

  typedef enum logic [1:0] {
    TK_READ,
    TK_WRITE,
    TK_POLL
  } xfer_e;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_DEVW,
    SRC_DEVR,
    SRC_WORD,
    SRC_DATA
  } wsrc_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RAM0,
    S_RAM1,
    S_RAM2,
    S_ISSUE,
    S_WAIT,
    S_POST,
    S_FIN
  } fsm_e;

  localparam logic [7:0] CRC_POLY = 8'h07;
endpackage

// File: rtl/cfg_crc8.sv
module cfg_crc8
  import cfg_nvm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] crc
);
  // one byte per cycle, unrolled shift stages, MSB first
  logic [7:0] stg [0:8];
  assign stg[0] = crc ^ din;

  for (genvar g = 0; g < 8; g++) begin : g_bit
    assign stg[g+1] = stg[g][7] ? ({stg[g][6:0], 1'b0} ^ CRC_POLY)
                                : {stg[g][6:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst || clr) crc <= 8'h00;
    else if (en)    crc <= stg[8];
  end

  // R4
  crc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (crc == 8'h00));
endmodule

// File: rtl/cfg_ee_addr.sv
module cfg_ee_addr #(
  parameter int NB = 4,
  parameter int BB = 32,
  parameter int EE_BASE = 224,
  parameter logic [6:0] DEV_BASE = 7'h50,
  localparam int BKW = (NB > 1) ? $clog2(NB) : 1,
  localparam int IXW = $clog2(BB + 1),
  localparam int RAW = $clog2(NB * BB)
) (
  input  logic [BKW-1:0] bank,
  input  logic [IXW-1:0] idx,
  output logic [10:0]    ee_addr,
  output logic [7:0]     dev_wr,
  output logic [7:0]     dev_rd,
  output logic [7:0]     word,
  output logic [RAW-1:0] ram_addr
);
  localparam int STRIDE = BB + 1;

  assign ee_addr  = 11'(32'(EE_BASE) + 32'(bank) * 32'(STRIDE) + 32'(idx));
  assign dev_wr   = {DEV_BASE[6:3], ee_addr[10:8], 1'b0};
  assign dev_rd   = {DEV_BASE[6:3], ee_addr[10:8], 1'b1};
  assign word     = ee_addr[7:0];
  assign ram_addr = RAW'(32'(bank) * 32'(BB) + 32'(idx));
endmodule

// File: rtl/cfg_nvm_loader.sv
module cfg_nvm_loader
  import cfg_nvm_pkg::*;
#(
  parameter int NB = 4,
  parameter int BB = 32,
  parameter int EE_BASE = 224,
  parameter logic [6:0] DEV_BASE = 7'h50,
  parameter int POLL_MAX = 64,
  localparam int RAW = $clog2(NB * BB)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_req,
  input  logic           store_req,
  output logic           busy,
  output logic           done,
  output logic           cfg_fault,
  output logic [NB-1:0]  bank_valid,
  output logic           ram_we,
  output logic [RAW-1:0] ram_addr,
  output logic [7:0]     ram_wdata,
  input  logic [7:0]     ram_rdata,
  output logic           i2c_req,
  output logic [1:0]     i2c_op,
  output logic [7:0]     i2c_wbyte,
  input  logic           i2c_done,
  input  logic           i2c_ack,
  input  logic [7:0]     i2c_rbyte
);
  localparam int BKW = (NB > 1) ? $clog2(NB) : 1;
  localparam int IXW = $clog2(BB + 1);
  localparam int PCW = $clog2(POLL_MAX + 1);
  localparam logic [IXW-1:0] IDX_CRC = IXW'(BB);
  localparam logic [BKW-1:0] BANK_LAST = BKW'(NB - 1);

  fsm_e            state_q;
  xfer_e           kind_q;
  logic [2:0]      step_q;
  logic            mode_store_q;
  logic [BKW-1:0]  bank_q;
  logic [IXW-1:0]  idx_q;
  logic [7:0]      rbyte_q, wbyte_q;
  logic            abort_q, poll_ack_q;
  logic [PCW-1:0]  poll_cnt_q;
  logic            busy_q, done_q, fault_q;
  logic [NB-1:0]   valid_q;
  logic            ram_we_q;
  logic [RAW-1:0]  ram_addr_q;
  logic [7:0]      ram_wdata_q;
  logic            req_q;
  i2c_op_e         op_q;
  logic [7:0]      wb_q;

  // address formatting
  logic [10:0]    ee_addr;
  logic [7:0]     dev_wr, dev_rd, word;
  logic [RAW-1:0] ram_a;

  cfg_ee_addr #(
    .NB(NB), .BB(BB), .EE_BASE(EE_BASE), .DEV_BASE(DEV_BASE)
  ) u_addr (
    .bank(bank_q), .idx(idx_q), .ee_addr(ee_addr),
    .dev_wr(dev_wr), .dev_rd(dev_rd), .word(word), .ram_addr(ram_a)
  );

  // check-byte accumulator
  logic       crc_clr, crc_en;
  logic [7:0] crc_din, crc_val;
  logic       bank_done;

  cfg_crc8 u_crc (
    .clk(clk), .rst(rst), .clr(crc_clr), .en(crc_en), .din(crc_din), .crc(crc_val)
  );

  wire accept    = (state_q == S_IDLE) && (load_req || store_req);
  wire bank_last = (bank_q == BANK_LAST);
  wire crc_ok    = (crc_val == rbyte_q);
  wire [IXW-1:0] idx_nx = idx_q + 1'b1;

  assign bank_done = (state_q == S_POST) && (idx_q == IDX_CRC) &&
                     (!mode_store_q || (kind_q == TK_POLL && poll_ack_q));
  assign crc_clr = accept || bank_done;
  assign crc_en  = (state_q == S_RAM2) ||
                   ((state_q == S_POST) && !mode_store_q && (idx_q != IDX_CRC));
  assign crc_din = mode_store_q ? ram_rdata : rbyte_q;

  // operation sequence per transfer kind
  i2c_op_e cur_op;
  wsrc_e   cur_src;
  logic    cur_last;

  always_comb begin
    cur_op   = OP_STOP;
    cur_src  = SRC_NONE;
    cur_last = 1'b0;
    unique case (kind_q)
      TK_READ: begin
        case (step_q)
          3'd0: cur_op = OP_START;
          3'd1: begin cur_op = OP_WRITE; cur_src = SRC_DEVW; end
          3'd2: begin cur_op = OP_WRITE; cur_src = SRC_WORD; end
          3'd3: cur_op = OP_START;
          3'd4: begin cur_op = OP_WRITE; cur_src = SRC_DEVR; end
          3'd5: cur_op = OP_READ;
          default: begin cur_op = OP_STOP; cur_last = 1'b1; end
        endcase
      end
      TK_WRITE: begin
        case (step_q)
          3'd0: cur_op = OP_START;
          3'd1: begin cur_op = OP_WRITE; cur_src = SRC_DEVW; end
          3'd2: begin cur_op = OP_WRITE; cur_src = SRC_WORD; end
          3'd3: begin cur_op = OP_WRITE; cur_src = SRC_DATA; end
          default: begin cur_op = OP_STOP; cur_last = 1'b1; end
        endcase
      end
      default: begin
        case (step_q)
          3'd0: cur_op = OP_START;
          3'd1: begin cur_op = OP_WRITE; cur_src = SRC_DEVW; end
          default: begin cur_op = OP_STOP; cur_last = 1'b1; end
        endcase
      end
    endcase
  end

  logic [7:0] tx_byte;
  always_comb begin
    unique case (cur_src)
      SRC_DEVW: tx_byte = dev_wr;
      SRC_DEVR: tx_byte = dev_rd;
      SRC_WORD: tx_byte = word;
      SRC_DATA: tx_byte = wbyte_q;
      default:  tx_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= S_IDLE;
      kind_q       <= TK_READ;
      step_q       <= '0;
      mode_store_q <= 1'b0;
      bank_q       <= '0;
      idx_q        <= '0;
      rbyte_q      <= '0;
      wbyte_q      <= '0;
      abort_q      <= 1'b0;
      poll_ack_q   <= 1'b0;
      poll_cnt_q   <= '0;
      busy_q       <= 1'b0;
      done_q       <= 1'b0;
      fault_q      <= 1'b0;
      valid_q      <= '0;
      ram_we_q     <= 1'b0;
      ram_addr_q   <= '0;
      ram_wdata_q  <= '0;
      req_q        <= 1'b0;
      op_q         <= OP_START;
      wb_q         <= '0;
    end else begin
      done_q   <= 1'b0;
      ram_we_q <= 1'b0;
      req_q    <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (accept) begin
            busy_q       <= 1'b1;
            fault_q      <= 1'b0;
            mode_store_q <= !load_req;
            bank_q       <= '0;
            idx_q        <= '0;
            abort_q      <= 1'b0;
            step_q       <= '0;
            if (load_req) begin
              valid_q <= '0;
              kind_q  <= TK_READ;
              state_q <= S_ISSUE;
            end else begin
              state_q <= S_RAM0;
            end
          end
        end
        S_RAM0: begin
          ram_addr_q <= ram_a;
          state_q    <= S_RAM1;
        end
        S_RAM1: state_q <= S_RAM2;
        S_RAM2: begin
          wbyte_q <= ram_rdata;
          kind_q  <= TK_WRITE;
          step_q  <= '0;
          state_q <= S_ISSUE;
        end
        S_ISSUE: begin
          req_q   <= 1'b1;
          op_q    <= abort_q ? OP_STOP : cur_op;
          wb_q    <= tx_byte;
          state_q <= S_WAIT;
        end
        S_WAIT: begin
          if (i2c_done) begin
            if (op_q == OP_READ) rbyte_q <= i2c_rbyte;
            if (op_q == OP_WRITE && kind_q == TK_POLL) poll_ack_q <= i2c_ack;
            if (op_q == OP_WRITE && kind_q != TK_POLL && !i2c_ack) begin
              abort_q <= 1'b1;
              fault_q <= 1'b1;
              state_q <= S_ISSUE;
            end else if (abort_q) begin
              state_q <= S_FIN;
            end else if (cur_last) begin
              state_q <= S_POST;
            end else begin
              step_q  <= step_q + 3'd1;
              state_q <= S_ISSUE;
            end
          end
        end
        S_POST: begin
          step_q <= '0;
          if (!mode_store_q) begin
            if (idx_q != IDX_CRC) begin
              ram_we_q    <= 1'b1;
              ram_addr_q  <= ram_a;
              ram_wdata_q <= rbyte_q;
              idx_q       <= idx_nx;
              state_q     <= S_ISSUE;
            end else begin
              valid_q[bank_q] <= crc_ok;
              if (!crc_ok) fault_q <= 1'b1;
              idx_q <= '0;
              if (bank_last) state_q <= S_FIN;
              else begin
                bank_q  <= bank_q + 1'b1;
                state_q <= S_ISSUE;
              end
            end
          end else if (kind_q == TK_WRITE) begin
            kind_q     <= TK_POLL;
            poll_cnt_q <= '0;
            state_q    <= S_ISSUE;
          end else if (poll_ack_q) begin
            poll_cnt_q <= '0;
            if (idx_q == IDX_CRC) begin
              idx_q <= '0;
              if (bank_last) state_q <= S_FIN;
              else begin
                bank_q  <= bank_q + 1'b1;
                state_q <= S_RAM0;
              end
            end else begin
              idx_q <= idx_nx;
              if (idx_nx == IDX_CRC) begin
                wbyte_q <= crc_val;
                kind_q  <= TK_WRITE;
                state_q <= S_ISSUE;
              end else begin
                state_q <= S_RAM0;
              end
            end
          end else if (poll_cnt_q == PCW'(POLL_MAX - 1)) begin
            fault_q <= 1'b1;
            state_q <= S_FIN;
          end else begin
            poll_cnt_q <= poll_cnt_q + 1'b1;
            state_q    <= S_ISSUE;
          end
        end
        S_FIN: begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy       = busy_q;
  assign done       = done_q;
  assign cfg_fault  = fault_q;
  assign bank_valid = valid_q;
  assign ram_we     = ram_we_q;
  assign ram_addr   = ram_addr_q;
  assign ram_wdata  = ram_wdata_q;
  assign i2c_req    = req_q;
  assign i2c_op     = op_q;
  assign i2c_wbyte  = wb_q;

  // outstanding-operation tracker for the handshake checks
  logic pend_q;
  always_ff @(posedge clk) begin
    if (rst)           pend_q <= 1'b0;
    else if (i2c_req)  pend_q <= 1'b1;
    else if (i2c_done) pend_q <= 1'b0;
  end

  // R10
  req_single_chk: assert property (@(posedge clk) disable iff (rst)
    i2c_req |=> !i2c_req);
  // R10
  req_pending_chk: assert property (@(posedge clk) disable iff (rst)
    i2c_req |-> !pend_q);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R3
  ram_we_busy_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> busy);
  // R5
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !load_req) |=> $stable(bank_valid));
  // R8
  poll_bound_chk: assert property (@(posedge clk) disable iff (rst)
    poll_cnt_q < PCW'(POLL_MAX));
endmodule

// File: tb/cfg_nvm_loader_tb.sv
`timescale 1ns/1ps
module cfg_nvm_loader_tb;
  localparam int NB = 4;
  localparam int BB = 32;
  localparam int EE_BASE = 224;
  localparam int POLL_MAX = 64;
  localparam int RAW = $clog2(NB * BB);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, load_req, store_req;
  logic busy, done, cfg_fault;
  logic [NB-1:0] bank_valid;
  logic ram_we;
  logic [RAW-1:0] ram_addr;
  logic [7:0] ram_wdata, ram_rdata;
  logic i2c_req;
  logic [1:0] i2c_op;
  logic [7:0] i2c_wbyte;
  logic i2c_done, i2c_ack;
  logic [7:0] i2c_rbyte;

  cfg_nvm_loader #(.NB(NB), .BB(BB), .EE_BASE(EE_BASE), .POLL_MAX(POLL_MAX)) u_dut (
    .clk(clk), .rst(rst), .load_req(load_req), .store_req(store_req),
    .busy(busy), .done(done), .cfg_fault(cfg_fault), .bank_valid(bank_valid),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .i2c_req(i2c_req), .i2c_op(i2c_op), .i2c_wbyte(i2c_wbyte),
    .i2c_done(i2c_done), .i2c_ack(i2c_ack), .i2c_rbyte(i2c_rbyte)
  );

  int checks = 0, fails = 0;

  // configuration RAM model, one-cycle read
  logic [7:0] ram [0:NB*BB-1];
  int ram_we_cnt = 0;
  always @(posedge clk) begin
    if (ram_we) begin ram[ram_addr] <= ram_wdata; ram_we_cnt <= ram_we_cnt + 1; end
    ram_rdata <= ram[ram_addr];
  end

  // EEPROM plus byte-master model
  logic [7:0] ee [0:2047];
  int m_phase, m_cnt, m_wbusy, busy_polls, ee_wr_cnt, req_cnt;
  logic [2:0] m_blk;
  logic [10:0] m_ptr, m_pa;
  logic [7:0] m_pd, r_byte;
  bit m_pw, absent, r_ack;
  logic [1:0] last_op;

  always @(posedge clk) begin
    i2c_done <= 1'b0;
    if (rst) begin
      m_cnt = 0; m_phase = 0; m_pw = 0; m_wbusy = 0;
      i2c_ack <= 1'b0; i2c_rbyte <= 8'h00;
    end else if (m_cnt > 0) begin
      m_cnt--;
      if (m_cnt == 0) begin i2c_done <= 1'b1; i2c_ack <= r_ack; i2c_rbyte <= r_byte; end
    end else if (i2c_req) begin
      req_cnt++;
      last_op = i2c_op;
      r_ack = 1'b0; r_byte = 8'h00;
      case (i2c_op)
        2'd0: begin m_phase = 1; r_ack = 1'b1; end
        2'd1: begin
          if (m_pw) begin ee[m_pa] = m_pd; ee_wr_cnt++; m_wbusy = busy_polls; m_pw = 0; end
          m_phase = 0;
        end
        2'd2: begin
          if (m_phase == 1) begin
            if (absent || i2c_wbyte[7:4] != 4'hA || m_wbusy > 0) begin
              if (m_wbusy > 0) m_wbusy--;
              m_phase = 0;
            end else begin
              r_ack = 1'b1; m_blk = i2c_wbyte[3:1];
              if (i2c_wbyte[0]) begin m_ptr = {i2c_wbyte[3:1], m_ptr[7:0]}; m_phase = 4; end
              else m_phase = 2;
            end
          end else if (m_phase == 2) begin
            m_ptr = {m_blk, i2c_wbyte}; r_ack = 1'b1; m_phase = 3;
          end else if (m_phase == 3) begin
            m_pw = 1; m_pa = m_ptr; m_pd = i2c_wbyte; r_ack = 1'b1; m_phase = 5;
          end
        end
        default: begin
          if (m_phase == 4) begin r_byte = ee[m_ptr]; m_ptr = m_ptr + 11'd1; end
        end
      endcase
      m_cnt = 1 + int'($urandom % 3);
    end
  end

  function automatic logic [7:0] crc_ref(input int b, input bit from_ee);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < BB; i++) begin
      logic [7:0] d = from_ee ? ee[EE_BASE + b*(BB+1) + i] : ram[b*BB + i];
      for (int k = 7; k >= 0; k--) begin
        logic fb = c[7] ^ d[k];
        c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
      end
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse(input bit ld, input bit st);
    @(negedge clk); load_req = ld; store_req = st;
    @(negedge clk); load_req = 1'b0; store_req = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 60000) begin @(negedge clk); n++; end
    check(done, "R9", "done timeout", int'(done), 1);
    check(!busy, "R9", "busy low with done", int'(busy), 0);
  endtask

  task automatic fill_ee(input logic [NB-1:0] bad);
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < BB; i++) ee[EE_BASE + b*(BB+1) + i] = 8'($urandom);
      ee[EE_BASE + b*(BB+1) + BB] = crc_ref(b, 1'b1) ^ (bad[b] ? 8'h5C : 8'h00);
    end
  endtask

  task automatic cmp_ram_ee(input string req);
    for (int b = 0; b < NB; b++) begin
      int mism = 0;
      for (int i = 0; i < BB; i++)
        if (ram[b*BB + i] !== ee[EE_BASE + b*(BB+1) + i]) mism++;
      check(mism == 0, req, $sformatf("bank %0d byte mismatches", b), mism, 0);
    end
  endtask

  initial begin
    int start_req;
    void'($urandom(32'd31415));
    rst = 1'b1; load_req = 1'b0; store_req = 1'b0;
    absent = 0; busy_polls = 0; ee_wr_cnt = 0; req_cnt = 0; last_op = 2'd0;
    for (int a = 0; a < 2048; a++) ee[a] = 8'hFF;
    for (int a = 0; a < NB*BB; a++) ram[a] = 8'h5A;
    repeat (4) @(negedge clk);
    // R1
    check(!busy && !done && !cfg_fault, "R1", "status after reset",
          int'({busy, done, cfg_fault}), 0);
    check(bank_valid == '0 && !ram_we && !i2c_req, "R1", "valid/strobes after reset",
          int'(bank_valid), 0);
    rst = 1'b0;

    // R2 R3: clean load across a 256-byte block boundary
    fill_ee('0);
    pulse(1'b1, 1'b0);
    check(busy, "R9", "busy after accept", int'(busy), 1);
    wait_done();
    cmp_ram_ee("R2");
    check(bank_valid == '1, "R5", "all banks valid", int'(bank_valid), (1 << NB) - 1);
    check(!cfg_fault, "R5", "no fault on clean load", int'(cfg_fault), 0);

    // R5: corrupted check bytes on banks 0 and 2
    fill_ee(4'b0101);
    for (int a = 0; a < NB*BB; a++) ram[a] = 8'h00;
    pulse(1'b1, 1'b0);
    wait_done();
    check(bank_valid == 4'b1010, "R5", "per-bank valid", int'(bank_valid), 4'b1010);
    check(cfg_fault, "R5", "fault on mismatch", int'(cfg_fault), 1);
    cmp_ram_ee("R5");

    // R7 R4: store, bank 1 all zero, device busy for two polls
    for (int a = 0; a < NB*BB; a++) ram[a] = (a / BB == 1) ? 8'h00 : 8'($urandom);
    busy_polls = 2; ee_wr_cnt = 0;
    pulse(1'b0, 1'b1);
    repeat (40) @(negedge clk);
    pulse(1'b1, 1'b0);   // R9: ignored while busy
    wait_done();
    cmp_ram_ee("R7");
    for (int b = 0; b < NB; b++)
      check(ee[EE_BASE + b*(BB+1) + BB] == crc_ref(b, 1'b0), "R4",
            $sformatf("check byte bank %0d", b),
            ee[EE_BASE + b*(BB+1) + BB], crc_ref(b, 1'b0));
    check(ee[EE_BASE + (BB+1) + BB] == 8'h00, "R4", "zero bank check byte",
          ee[EE_BASE + (BB+1) + BB], 0);
    check(ee_wr_cnt == NB*(BB+1), "R7", "byte writes", ee_wr_cnt, NB*(BB+1));
    check(!cfg_fault, "R7", "no fault on store", int'(cfg_fault), 0);
    check(bank_valid == 4'b1010, "R9", "load during busy ignored", int'(bank_valid), 4'b1010);
    start_req = req_cnt;
    repeat (20) @(negedge clk);
    check(!busy && req_cnt == start_req, "R9", "idle after done", req_cnt - start_req, 0);

    // R9: both requests together -> load
    ee_wr_cnt = 0; busy_polls = 0;
    pulse(1'b1, 1'b1);
    wait_done();
    check(bank_valid == '1, "R9", "load chosen", int'(bank_valid), (1 << NB) - 1);
    check(ee_wr_cnt == 0, "R9", "no writes when load chosen", ee_wr_cnt, 0);

    // R6: absent device aborts the load
    absent = 1; ram_we_cnt = 0;
    pulse(1'b1, 1'b0);
    wait_done();
    check(cfg_fault, "R6", "fault on nack", int'(cfg_fault), 1);
    check(bank_valid == '0, "R6", "valid cleared", int'(bank_valid), 0);
    check(last_op == 2'd1, "R6", "stop issued last", int'(last_op), 1);
    check(ram_we_cnt == 0, "R6", "no RAM writes", ram_we_cnt, 0);
    absent = 0;

    // R8: device never finishes its write cycle
    busy_polls = 1000; ee_wr_cnt = 0;
    pulse(1'b0, 1'b1);
    wait_done();
    check(cfg_fault, "R8", "poll timeout fault", int'(cfg_fault), 1);
    check(ee_wr_cnt == 1, "R8", "single byte written", ee_wr_cnt, 1);
    @(negedge clk); rst = 1'b1; busy_polls = 0;
    repeat (2) @(negedge clk); rst = 1'b0;
    check(!busy && bank_valid == '0, "R1", "state after second reset", int'(bank_valid), 0);

    // random loads with random corruption masks
    for (int it = 0; it < 2; it++) begin
      logic [NB-1:0] bad = NB'($urandom);
      fill_ee(bad);
      pulse(1'b1, 1'b0);
      wait_done();
      cmp_ram_ee("R3");
      check(bank_valid == ~bad, "R5", "random valid mask", int'(bank_valid), int'(~bad));
      check(cfg_fault == (bad != '0), "R5", "random fault", int'(cfg_fault), int'(bad != '0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule